// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Bank

This block keeps eight one-bit ownership tokens that two independent ports, left and right, use to share resources. Each port has a memory chip enable, a semaphore select, a read/write line, an output enable, a 3-bit token index and a data bus. To claim a token, a port writes a 0 in data bit 0 to it. It then reads the token back and owns it only if it sees 0. To hand the token back, the port writes a 1. The block settles claims that arrive in the same cycle, queues one waiting claim for each side, and reports the holder of every token on two status vectors.

All state changes on the rising clock edge. Reads are combinational from the current state. A cycle in which one port asserts its memory enable and its semaphore select together is illegal. The block discards such a cycle and raises an error flag for that port on the next cycle.

Top module: `sem_bank`

## Requirements
- R1: The bank has eight tokens, chosen by a 3-bit index from either port. After reset every token is free: `tok_held` is 0, `tok_right` is 0, and a valid read from either port returns all ones.
- R2: A valid write holds `ce_n`=1, `sem_n`=0 and `rw`=0. If the token is free and data bit 0 is 0, the writer takes it. On the next cycle the token's bit in `tok_held` is 1, and its bit in `tok_right` is 1 if the right port took it and 0 if the left port took it.
- R3: A claim (bit 0 = 0) on a token that the other port holds leaves the holder unchanged. The claim is recorded as pending for the claiming port.
- R4: A write of bit 0 = 1 by the holder releases the token. If the other port has a pending claim, the token passes to that port. Otherwise the token becomes free, and both its `tok_held` and `tok_right` bits read 0.
- R5: A write of bit 0 = 1 by a port that does not hold the token leaves ownership unchanged. It withdraws that port's own pending claim.
- R6: If both ports claim the same free token in one cycle, the left port wins and the right claim becomes pending. If the holder releases and the other port claims in the same cycle, the release is applied first, so the claimer gets the token.
- R7: A valid read holds `ce_n`=1, `sem_n`=0, `rw`=1 and `oe_n`=0. It returns 0 on every data bit when the reader holds the indexed token, and 1 on every bit otherwise. When no valid read is present, `rdata` is all zeros.
- R8: A cycle with `ce_n`=0 and `sem_n`=0 on a port changes no token, returns zeros on `rdata`, and sets that port's `err` high on the next cycle. `err` is low after any other cycle.
- R9: Only data bit 0 of a write is used. The other data bits have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_ce_n | input | 1 | Left memory chip enable, active low |
| l_sem_n | input | 1 | Left semaphore select, active low |
| l_rw | input | 1 | Left read (1) / write (0) |
| l_oe_n | input | 1 | Left output enable, active low |
| l_idx | input | 3 | Left token index |
| l_wdata | input | DW | Left write data; only bit 0 is used |
| l_rdata | output | DW | Left read data |
| l_err | output | 1 | Left illegal-cycle flag |
| r_ce_n | input | 1 | Right memory chip enable, active low |
| r_sem_n | input | 1 | Right semaphore select, active low |
| r_rw | input | 1 | Right read (1) / write (0) |
| r_oe_n | input | 1 | Right output enable, active low |
| r_idx | input | 3 | Right token index |
| r_wdata | input | DW | Right write data; only bit 0 is used |
| r_rdata | output | DW | Right read data |
| r_err | output | 1 | Right illegal-cycle flag |
| tok_held | output | 8 | One bit per token; 1 while the token is held |
| tok_right | output | 8 | One bit per token; 1 while the right port holds it |

## Verification
Some rules are checked by the assertions on every cycle:
- A token held by the left port stays with the left port unless the left port releases it, and the same holds for the right port.
- A pending claim exists only while the other port holds the token.
- Cycles with no valid write leave all token state unchanged.
- Each `err` flag follows the illegal-cycle condition one cycle later.
- Read data is always all zeros or all ones.

Other behaviours depend on a particular sequence of operations, so only the bench scenarios show them. These include the handover to a waiting claimer, the withdrawal of a pending claim, the left-wins tie-break, and release-before-claim ordering in the same cycle. They also include the split between the two ports' read views and the insensitivity to the upper data bits.

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int DW   = 16,
  parameter int NSEM = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    l_ce_n,
  input  logic                    l_sem_n,
  input  logic                    l_rw,
  input  logic                    l_oe_n,
  input  logic [$clog2(NSEM)-1:0] l_idx,
  input  logic [DW-1:0]           l_wdata,
  output logic [DW-1:0]           l_rdata,
  output logic                    l_err,
  input  logic                    r_ce_n,
  input  logic                    r_sem_n,
  input  logic                    r_rw,
  input  logic                    r_oe_n,
  input  logic [$clog2(NSEM)-1:0] r_idx,
  input  logic [DW-1:0]           r_wdata,
  output logic [DW-1:0]           r_rdata,
  output logic                    r_err,
  output logic [NSEM-1:0]         tok_held,
  output logic [NSEM-1:0]         tok_right
);
  localparam int IW = $clog2(NSEM);

  logic l_wr, r_wr, l_rd, r_rd, l_ill, r_ill;
  logic [NSEM-1:0] held, own_r, pend_l, pend_r;
  logic l_view, r_view;

  assign l_ill = ~l_ce_n & ~l_sem_n;
  assign r_ill = ~r_ce_n & ~r_sem_n;
  assign l_wr  = l_ce_n & ~l_sem_n & ~l_rw;
  assign r_wr  = r_ce_n & ~r_sem_n & ~r_rw;
  assign l_rd  = l_ce_n & ~l_sem_n & l_rw & ~l_oe_n;
  assign r_rd  = r_ce_n & ~r_sem_n & r_rw & ~r_oe_n;

  assign l_view  = ~(held[l_idx] & ~own_r[l_idx]);
  assign r_view  = ~(held[r_idx] & own_r[r_idx]);
  assign l_rdata = l_rd ? {DW{l_view}} : '0;
  assign r_rdata = r_rd ? {DW{r_view}} : '0;

  assign tok_held  = held;
  assign tok_right = own_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_err <= 1'b0;
      r_err <= 1'b0;
    end else begin
      l_err <= l_ill;
      r_err <= r_ill;
    end
  end

  for (genvar i = 0; i < NSEM; i++) begin : g_tok
    logic hit_l, hit_r, req_l, req_r, rel_l, rel_r;
    logic h_n, o_n, pl_n, pr_n;

    assign hit_l = l_wr && (l_idx == IW'(i));
    assign hit_r = r_wr && (r_idx == IW'(i));
    assign req_l = hit_l & ~l_wdata[0];
    assign rel_l = hit_l &  l_wdata[0];
    assign req_r = hit_r & ~r_wdata[0];
    assign rel_r = hit_r &  r_wdata[0];

    always_comb begin
      h_n  = held[i];
      o_n  = own_r[i];
      pl_n = pend_l[i];
      pr_n = pend_r[i];
      if (rel_l) begin
        pl_n = 1'b0;
        if (h_n && !o_n) begin
          if (pr_n) begin
            o_n  = 1'b1;
            pr_n = 1'b0;
          end else begin
            h_n = 1'b0;
            o_n = 1'b0;
          end
        end
      end
      if (rel_r) begin
        pr_n = 1'b0;
        if (h_n && o_n) begin
          if (pl_n) begin
            o_n  = 1'b0;
            pl_n = 1'b0;
          end else begin
            h_n = 1'b0;
            o_n = 1'b0;
          end
        end
      end
      if (req_l) begin
        if (!h_n) begin
          h_n = 1'b1;
          o_n = 1'b0;
        end else if (o_n) begin
          pl_n = 1'b1;
        end
      end
      if (req_r) begin
        if (!h_n) begin
          h_n = 1'b1;
          o_n = 1'b1;
        end else if (!o_n) begin
          pr_n = 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        held[i]   <= 1'b0;
        own_r[i]  <= 1'b0;
        pend_l[i] <= 1'b0;
        pend_r[i] <= 1'b0;
      end else begin
        held[i]   <= h_n;
        own_r[i]  <= o_n;
        pend_l[i] <= pl_n;
        pend_r[i] <= pr_n;
      end
    end

    // R5
    left_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (held[i] && !own_r[i] && !rel_l) |=> (held[i] && !own_r[i]));
    // R5
    right_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (held[i] && own_r[i] && !rel_r) |=> (held[i] && own_r[i]));
    // R3
    pend_l_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_l[i] |-> (held[i] && own_r[i]));
    // R3
    pend_r_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_r[i] |-> (held[i] && !own_r[i]));
  end

  // R8
  no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_wr && !r_wr) |=> ($stable(held) && $stable(own_r)));
  // R8
  l_err_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_ill |=> l_err);
  // R8
  l_err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !l_ill |=> !l_err);
  // R8
  r_err_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_ill |=> r_err);
  // R8
  r_err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !r_ill |=> !r_err);
  // R7
  rdata_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((l_rdata == '0) || (l_rdata == '1)) && ((r_rdata == '0) || (r_rdata == '1)));
  // R7
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_rd |-> (l_rdata == '0)) and (!r_rd |-> (r_rdata == '0)));
endmodule

// File: tb/sim_sem_bank.sv
module sim_sem_bank;
  localparam int DW = 16;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_ce_n, l_sem_n, l_rw, l_oe_n, r_ce_n, r_sem_n, r_rw, r_oe_n;
  logic [2:0] l_idx, r_idx;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic l_err, r_err;
  logic [7:0] tok_held, tok_right;
  int nchk = 0;
  int nbad = 0;

  always #2.5 clk = ~clk;

  sem_bank #(.DW(DW), .NSEM(8)) u0 (
    .clk(clk), .rst_n(rst_n),
    .l_ce_n(l_ce_n), .l_sem_n(l_sem_n), .l_rw(l_rw), .l_oe_n(l_oe_n),
    .l_idx(l_idx), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_err(l_err),
    .r_ce_n(r_ce_n), .r_sem_n(r_sem_n), .r_rw(r_rw), .r_oe_n(r_oe_n),
    .r_idx(r_idx), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_err(r_err),
    .tok_held(tok_held), .tok_right(tok_right));

  // op: 0 idle, 1 write, 2 read, 3 illegal (ce_n=0, sem_n=0, rw=0)
  // fields: lop lidx ld | rop ridx rd | held right
  localparam logic [27:0] VEC [NV] = '{
    {2'd1,3'd2,1'b0, 2'd0,3'd0,1'b0, 8'h04,8'h00}, // R2 left takes 2
    {2'd0,3'd0,1'b0, 2'd1,3'd2,1'b0, 8'h04,8'h00}, // R3 right pends on 2
    {2'd0,3'd0,1'b0, 2'd1,3'd2,1'b1, 8'h04,8'h00}, // R5 right withdraws
    {2'd1,3'd2,1'b1, 2'd0,3'd0,1'b0, 8'h00,8'h00}, // R4 release, no waiter
    {2'd1,3'd5,1'b0, 2'd1,3'd5,1'b0, 8'h20,8'h00}, // R6 tie, left wins
    {2'd1,3'd5,1'b1, 2'd0,3'd0,1'b0, 8'h20,8'h20}, // R4 handover to right
    {2'd1,3'd5,1'b1, 2'd0,3'd0,1'b0, 8'h20,8'h20}, // R5 non-owner release
    {2'd1,3'd7,1'b0, 2'd1,3'd0,1'b0, 8'hA1,8'h21}, // R2 both take others
    {2'd3,3'd3,1'b0, 2'd3,3'd4,1'b0, 8'hA1,8'h21}, // R8 illegal ignored
    {2'd1,3'd5,1'b0, 2'd1,3'd5,1'b1, 8'hA1,8'h01}, // R6 release then claim
    {2'd1,3'd7,1'b1, 2'd1,3'd0,1'b1, 8'h20,8'h00}, // R4 two releases
    {2'd1,3'd5,1'b1, 2'd0,3'd0,1'b0, 8'h00,8'h00}  // R4 all free
  };

  task automatic drive_l(input logic [1:0] op, input logic [2:0] ix, input logic d);
    l_ce_n  = (op != 2'd3);
    l_sem_n = (op == 2'd0);
    l_rw    = (op == 2'd2);
    l_oe_n  = (op != 2'd2);
    l_idx   = ix;
    l_wdata = {{(DW-1){~d}}, d};
  endtask

  task automatic drive_r(input logic [1:0] op, input logic [2:0] ix, input logic d);
    r_ce_n  = (op != 2'd3);
    r_sem_n = (op == 2'd0);
    r_rw    = (op == 2'd2);
    r_oe_n  = (op != 2'd2);
    r_idx   = ix;
    r_wdata = {{(DW-1){~d}}, d};
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    drive_l(2'd0, 3'd0, 1'b1);
    drive_r(2'd0, 3'd0, 1'b1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 held", 32'(tok_held), 32'h0);
    check("R1 right", 32'(tok_right), 32'h0);
    drive_l(2'd2, 3'd6, 1'b0);
    drive_r(2'd2, 3'd1, 1'b0);
    #1;
    check("R1 l read free", 32'(l_rdata), 32'hFFFF);
    check("R1 r read free", 32'(r_rdata), 32'hFFFF);
    check("R8 err low", 32'({l_err, r_err}), 32'h0);
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      drive_l(VEC[v][27:26], VEC[v][25:23], VEC[v][22]);
      drive_r(VEC[v][21:20], VEC[v][19:17], VEC[v][16]);
      @(negedge clk);
      drive_l(2'd0, 3'd0, 1'b1);
      drive_r(2'd0, 3'd0, 1'b1);
      check($sformatf("R2-R6 vec%0d held", v), 32'(tok_held), 32'(VEC[v][15:8]));
      check($sformatf("R2-R6 vec%0d right", v), 32'(tok_right), 32'(VEC[v][7:0]));
      if (VEC[v][27:26] == 2'd3)
        check("R8 err after illegal", 32'({l_err, r_err}), 32'h3);
    end

    // R7 read views; R9 upper data bits set but bit0 = 0 claims
    drive_l(2'd1, 3'd3, 1'b0);
    @(negedge clk);
    drive_l(2'd2, 3'd3, 1'b0);
    drive_r(2'd2, 3'd3, 1'b0);
    #1;
    check("R7 owner reads zero", 32'(l_rdata), 32'h0000);
    check("R7 other reads ones", 32'(r_rdata), 32'hFFFF);
    check("R9 claim with upper bits", 32'(tok_held), 32'h08);
    l_oe_n = 1'b1;
    #0.5;
    check("R7 oe high gives zeros", 32'(l_rdata), 32'h0);
    @(negedge clk);

    // R8 illegal read: zeros, err next cycle, no change
    drive_l(2'd0, 3'd3, 1'b0);
    l_ce_n = 1'b0; l_sem_n = 1'b0; l_rw = 1'b1; l_oe_n = 1'b0;
    drive_r(2'd0, 3'd0, 1'b1);
    #1;
    check("R8 illegal read zeros", 32'(l_rdata), 32'h0);
    @(negedge clk);
    drive_l(2'd0, 3'd0, 1'b1);
    check("R8 l err set", 32'(l_err), 32'h1);
    check("R8 r err clear", 32'(r_err), 32'h0);
    @(negedge clk);
    check("R8 l err clears", 32'(l_err), 32'h0);
    check("R8 state kept", 32'(tok_held), 32'h08);

    // R9 release with upper bits zero
    drive_l(2'd1, 3'd3, 1'b1);
    @(negedge clk);
    drive_l(2'd0, 3'd0, 1'b1);
    check("R9 release bit0 only", 32'(tok_held), 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule